// File: doc/BRIEF.md
# Three-wire control bus transmit master

This block sends short write messages over a three-wire serial control bus made of a clock line, a data line and a mode line. A client gives it an address byte and a burst length. The block then asks for the data bytes one at a time through a valid/ready handshake and sends each one out. Nothing is ever read back from the slave, and the block does not interpret the bytes it carries.

The mode line tells the slave which phase is active. It is low while the address byte is sent and high while a data byte is sent. Between two data bytes it drops low for a short pulse. It does not pulse before the first data byte or after the last one.

Six timing values come in as cycle counts of the system clock. A count of zero still lasts one cycle. The bit timing, the phase changes and the idle levels are all derived from these counts, so one block can serve slow and fast slaves. The timing inputs must stay steady while a transfer is running.

Top module: `ctlbus_tx_master`

## Requirements
- R1: After reset, and whenever no transfer is running, the pins are clock high, data high and mode low. busy, done and byteReady are low.
- R2: A start request is accepted only when the block is idle and the length is between 1 and MAX_LEN. From the next cycle, clock, data and mode are all high for W(tModePulse) cycles, where W(n) is n, or 1 when n is 0.
- R3: After that preamble, mode goes low for W(tModeSetup) cycles with clock and data high. The address byte is then sent least significant bit first, with mode low throughout.
- R4: Each bit takes three steps. First, clock is low for W(tHold) cycles while data keeps the previous level. Next, clock stays low for W(tSetup) cycles with the new bit on data. Last, clock is high for W(tHigh) cycles with the bit held. Data and mode never change on a rising clock.
- R5: After the address byte, mode stays low and clock high for W(tModeHold) cycles.
- R6: Before each data byte, a fetch step raises byteReady with mode low and clock high. The step lasts until byteValid is high. The byte on byteData is taken on the clock edge where byteValid and byteReady are both high.
- R7: Each data byte is preceded by W(tModeSetup) cycles of mode high. Mode then stays high through all eight bits of the byte, sent least significant bit first.
- R8: Between two consecutive data bytes, mode is high for W(tModeHold) cycles and then low for W(tModePulse) cycles, before the next fetch step. This gap never appears before the first data byte or after the last one.
- R9: After the last bit there is exactly one cycle with clock high, data high, mode low, busy high and done high. In that cycle doneCount equals the accepted length. The block is then idle.
- R10: A start request that arrives while busy is high has no effect on the pins or on the transfer in progress.
- R11: A start request with a length of 0 or greater than MAX_LEN is ignored, and the block stays idle.
- R12: busy is high from the cycle after an accepted start through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin a transfer |
| addrByte | input | 8 | Address byte, captured at start |
| dataLen | input | LEN_W | Number of data bytes, captured at start |
| tHold | input | CNT_W | Clock-low time before a new bit is presented |
| tSetup | input | CNT_W | Clock-low time with the new bit presented |
| tHigh | input | CNT_W | Clock-high time per bit |
| tModeHold | input | CNT_W | Wait after a byte, before any mode change |
| tModePulse | input | CNT_W | Width of the preamble and of the gap pulse between data bytes |
| tModeSetup | input | CNT_W | Wait after a mode change, before the first bit |
| byteValid | input | 1 | Next data byte is on byteData |
| byteData | input | 8 | Data byte |
| byteReady | output | 1 | Block is waiting for a data byte |
| busClk | output | 1 | Bus clock line level |
| busData | output | 1 | Bus data line level |
| busMode | output | 1 | Bus mode line level |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| doneCount | output | LEN_W | Number of data bytes in the last transfer |

## Verification
An accepted start is sampled on the rising edge. The preamble levels appear one cycle later, and after that every pin, busy, done and byteReady change only on rising edges. The bench therefore builds a queue of expected levels, one entry per cycle, from the timing counts, the bytes and the planned handshake stall. It compares one entry per clock at the falling edge, halfway between edges. The bench drives byteValid at the falling edge after byteReady has been seen, so each fetch step lasts exactly one cycle more than the planned stall. When the queue is empty, the bench expects the idle levels, and these cycles are used to show that ignored starts leave the block untouched.

// File: rtl/ctlbus_tx_pkg.sv
package ctlbus_tx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_ASETUP,
    ST_BLOW,
    ST_BDATA,
    ST_BHIGH,
    ST_AHOLD,
    ST_GHOLD,
    ST_GLOW,
    ST_FETCH,
    ST_DSETUP,
    ST_DONE
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureStart;
    logic loadByte;
    logic presentBit;
    logic goIdle;
  } dpStrobe_t;

endpackage

// File: rtl/ctlbus_tx_dpath.sv
module ctlbus_tx_dpath
  import ctlbus_tx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [BYTE_W-1:0] addrByte,
  input  logic [BYTE_W-1:0] byteData,
  output logic              busData
);

  logic [BYTE_W-1:0] shiftReg;
  logic              dataPin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataPin  <= 1'b1;
    end else begin
      if (strb.captureStart) begin
        shiftReg <= addrByte;
      end else if (strb.loadByte) begin
        shiftReg <= byteData;
      end else if (strb.presentBit) begin
        shiftReg <= {1'b0, shiftReg[BYTE_W-1:1]};
      end
      if (strb.presentBit) begin
        dataPin <= shiftReg[0];
      end else if (strb.goIdle) begin
        dataPin <= 1'b1;
      end
    end
  end

  assign busData = dataPin;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.captureStart, strb.loadByte, strb.presentBit, strb.goIdle}) <= 1) else $error("strobe overlap"); // R4

endmodule

// File: rtl/ctlbus_tx_ctrl.sv
module ctlbus_tx_ctrl
  import ctlbus_tx_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MAX_LEN = 4,
  parameter int BYTE_W  = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int BIT_W  = $clog2(BYTE_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LEN_W-1:0] dataLen,
  input  logic [CNT_W-1:0] tHold,
  input  logic [CNT_W-1:0] tSetup,
  input  logic [CNT_W-1:0] tHigh,
  input  logic [CNT_W-1:0] tModeHold,
  input  logic [CNT_W-1:0] tModePulse,
  input  logic [CNT_W-1:0] tModeSetup,
  input  logic             byteValid,
  output logic             byteReady,
  output logic             busClk,
  output logic             busMode,
  output logic             busy,
  output logic             done,
  output logic [LEN_W-1:0] doneCount,
  output dpStrobe_t        strb
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MAX_LEN);

  txState_t         state, nextState;
  logic [CNT_W-1:0] timer, nextTimer;
  logic [BIT_W-1:0] bitCnt;
  logic [LEN_W-1:0] byteIdx;
  logic [LEN_W-1:0] lenReg;
  logic             inAddr;
  logic             lenOk, timerZero, lastByte;
  logic             clrBit, incBit, incByte, leaveAddr;

  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  assign lenOk     = (dataLen != '0) && (dataLen <= LEN_MAX);
  assign timerZero = (timer == '0);
  assign lastByte  = (byteIdx == lenReg - 1'b1);

  always_comb begin
    nextState = state;
    nextTimer = timerZero ? timer : timer - 1'b1;
    strb      = '0;
    clrBit    = 1'b0;
    incBit    = 1'b0;
    incByte   = 1'b0;
    leaveAddr = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq && lenOk) begin
        nextState         = ST_PRE;
        nextTimer         = span(tModePulse);
        strb.captureStart = 1'b1;
      end
      ST_PRE: if (timerZero) begin
        nextState = ST_ASETUP;
        nextTimer = span(tModeSetup);
      end
      ST_ASETUP, ST_DSETUP: if (timerZero) begin
        nextState = ST_BLOW;
        nextTimer = span(tHold);
        clrBit    = 1'b1;
      end
      ST_BLOW: if (timerZero) begin
        nextState       = ST_BDATA;
        nextTimer       = span(tSetup);
        strb.presentBit = 1'b1;
      end
      ST_BDATA: if (timerZero) begin
        nextState = ST_BHIGH;
        nextTimer = span(tHigh);
      end
      ST_BHIGH: if (timerZero) begin
        if (bitCnt != LAST_BIT) begin
          nextState = ST_BLOW;
          nextTimer = span(tHold);
          incBit    = 1'b1;
        end else if (inAddr) begin
          nextState = ST_AHOLD;
          nextTimer = span(tModeHold);
        end else if (lastByte) begin
          nextState   = ST_DONE;
          strb.goIdle = 1'b1;
        end else begin
          nextState = ST_GHOLD;
          nextTimer = span(tModeHold);
          incByte   = 1'b1;
        end
      end
      ST_AHOLD: if (timerZero) nextState = ST_FETCH;
      ST_GHOLD: if (timerZero) begin
        nextState = ST_GLOW;
        nextTimer = span(tModePulse);
      end
      ST_GLOW: if (timerZero) nextState = ST_FETCH;
      ST_FETCH: if (byteValid) begin
        nextState     = ST_DSETUP;
        nextTimer     = span(tModeSetup);
        strb.loadByte = 1'b1;
        leaveAddr     = 1'b1;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      bitCnt  <= '0;
      byteIdx <= '0;
      lenReg  <= '0;
      inAddr  <= 1'b0;
    end else begin
      state <= nextState;
      timer <= nextTimer;
      if (clrBit) bitCnt <= '0;
      else if (incBit) bitCnt <= bitCnt + 1'b1;
      if (strb.captureStart) begin
        lenReg  <= dataLen;
        byteIdx <= '0;
        inAddr  <= 1'b1;
      end else begin
        if (incByte) byteIdx <= byteIdx + 1'b1;
        if (leaveAddr) inAddr <= 1'b0;
      end
    end
  end

  always_comb begin
    busClk    = !(state == ST_BLOW || state == ST_BDATA);
    byteReady = (state == ST_FETCH);
    busy      = (state != ST_IDLE);
    done      = (state == ST_DONE);
    unique case (state)
      ST_PRE, ST_GHOLD, ST_DSETUP:    busMode = 1'b1;
      ST_BLOW, ST_BDATA, ST_BHIGH:    busMode = !inAddr;
      default:                        busMode = 1'b0;
    endcase
  end

  assign doneCount = lenReg;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done wider than one cycle"); // R9
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (doneCount != '0) && (doneCount <= LEN_MAX)) else $error("bad count"); // R9
  AST_MODE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busClk) |-> $stable(busMode)) else $error("mode moved on rising clock"); // R4
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> busy && busClk && !busMode) else $error("ready outside fetch"); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy) else $error("busy dropped early"); // R12
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq && lenOk) |=> busy && busClk && busMode) else $error("start not taken"); // R2

endmodule

// File: rtl/ctlbus_tx_master.sv
module ctlbus_tx_master
  import ctlbus_tx_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MAX_LEN = 4,
  localparam int BYTE_W = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [BYTE_W-1:0] addrByte,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic [CNT_W-1:0]  tHold,
  input  logic [CNT_W-1:0]  tSetup,
  input  logic [CNT_W-1:0]  tHigh,
  input  logic [CNT_W-1:0]  tModeHold,
  input  logic [CNT_W-1:0]  tModePulse,
  input  logic [CNT_W-1:0]  tModeSetup,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output logic              byteReady,
  output logic              busClk,
  output logic              busData,
  output logic              busMode,
  output logic              busy,
  output logic              done,
  output logic [LEN_W-1:0]  doneCount
);

  dpStrobe_t strb;

  ctlbus_tx_ctrl #(
    .CNT_W  (CNT_W),
    .MAX_LEN(MAX_LEN),
    .BYTE_W (BYTE_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .dataLen   (dataLen),
    .tHold     (tHold),
    .tSetup    (tSetup),
    .tHigh     (tHigh),
    .tModeHold (tModeHold),
    .tModePulse(tModePulse),
    .tModeSetup(tModeSetup),
    .byteValid (byteValid),
    .byteReady (byteReady),
    .busClk    (busClk),
    .busMode   (busMode),
    .busy      (busy),
    .done      (done),
    .doneCount (doneCount),
    .strb      (strb)
  );

  ctlbus_tx_dpath #(
    .BYTE_W(BYTE_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addrByte(addrByte),
    .byteData(byteData),
    .busData (busData)
  );

endmodule

// File: tb/ctlbus_tx_master_bench.sv
module ctlbus_tx_master_bench;

  localparam int CNT_W   = 8;
  localparam int MAX_LEN = 4;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  typedef struct {
    bit c, d, m, b, dn, r;
    int req;
    int cnt;
  } expCycle_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [7:0] addrByte = '0;
  logic [LEN_W-1:0] dataLen = '0;
  logic [CNT_W-1:0] tHold = '0, tSetup = '0, tHigh = '0;
  logic [CNT_W-1:0] tModeHold = '0, tModePulse = '0, tModeSetup = '0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic byteReady, busClk, busData, busMode, busy, done;
  logic [LEN_W-1:0] doneCount;

  expCycle_t expQ[$];
  logic [7:0] dataQ[$];
  int checks = 0, errors = 0, cycles = 0;
  int idleTag = 1;      // requirement tag for idle cycles: R1, R10, R11
  int curStall = 0, stallCnt = 0;
  bit running = 1'b0;   // compare enabled
  bit reported = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ctlbus_tx_master u_ctlbus_tx_master (
    .clk(clk), .rstN(rstN), .startReq(startReq), .addrByte(addrByte),
    .dataLen(dataLen), .tHold(tHold), .tSetup(tSetup), .tHigh(tHigh),
    .tModeHold(tModeHold), .tModePulse(tModePulse), .tModeSetup(tModeSetup),
    .byteValid(byteValid), .byteData(byteData), .byteReady(byteReady),
    .busClk(busClk), .busData(busData), .busMode(busMode), .busy(busy),
    .done(done), .doneCount(doneCount)
  );

  function automatic int widthOf(input logic [CNT_W-1:0] n);
    return (n == 0) ? 1 : int'(n);
  endfunction

  task automatic push(input int n, input bit c, input bit d, input bit m,
                      input bit r, input bit dn, input int req, input int cnt);
    expCycle_t e;
    e.c = c; e.d = d; e.m = m; e.b = 1'b1; e.dn = dn; e.r = r; e.req = req; e.cnt = cnt;
    for (int i = 0; i < n; i++) expQ.push_back(e);
  endtask

  // bit timing, R4; mode level given by caller (R3 for address, R7 for data)
  task automatic pushByte(input logic [7:0] v, input bit m, inout bit last);
    for (int i = 0; i < 8; i++) begin
      push(widthOf(tHold), 0, last, m, 0, 0, 4, 0);
      push(widthOf(tSetup), 0, v[i], m, 0, 0, 4, 0);
      push(widthOf(tHigh), 1, v[i], m, 0, 0, m ? 7 : 3, 0);
      last = v[i];
    end
  endtask

  task automatic modelTransfer(input logic [7:0] a, input logic [7:0] bytes[$], input int stall);
    bit last = 1'b1;
    push(widthOf(tModePulse), 1, 1, 1, 0, 0, 2, 0);          // R2 preamble
    push(widthOf(tModeSetup), 1, 1, 0, 0, 0, 3, 0);          // R3
    pushByte(a, 1'b0, last);
    push(widthOf(tModeHold), 1, last, 0, 0, 0, 5, 0);        // R5
    for (int k = 0; k < bytes.size(); k++) begin
      if (k > 0) begin
        push(widthOf(tModeHold), 1, last, 1, 0, 0, 8, 0);    // R8
        push(widthOf(tModePulse), 1, last, 0, 0, 0, 8, 0);   // R8
      end
      push(stall + 1, 1, last, 0, 1, 0, 6, 0);               // R6
      push(widthOf(tModeSetup), 1, last, 1, 0, 0, 7, 0);     // R7
      pushByte(bytes[k], 1'b1, last);
    end
    push(1, 1, 1, 0, 0, 1, 9, bytes.size());                 // R9, R12
  endtask

  task automatic fail(input int req, input string what, input int act, input int ex);
    errors++;
    $display("FAIL R%0d %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, ex, cycles);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  // per-cycle compare at the falling edge, then handshake driver
  always @(negedge clk) begin
    expCycle_t e;
    cycles++;
    if (running) begin
      if (expQ.size() != 0) e = expQ.pop_front();
      else begin
        e.c = 1; e.d = 1; e.m = 0; e.b = 0; e.dn = 0; e.r = 0; e.req = idleTag; e.cnt = 0;
      end
      checks++;
      if ({busClk, busData, busMode} !== {e.c, e.d, e.m})
        fail(e.req, "pins clk/data/mode", int'({busClk, busData, busMode}), int'({e.c, e.d, e.m}));
      else if (busy !== e.b) fail(e.req == 9 ? 12 : e.req, "busy", int'(busy), int'(e.b));
      else if (done !== e.dn) fail(e.req, "done", int'(done), int'(e.dn));
      else if (byteReady !== e.r) fail(e.req, "byteReady", int'(byteReady), int'(e.r));
      else if (e.dn && int'(doneCount) != e.cnt) fail(9, "doneCount", int'(doneCount), e.cnt);
    end
    if (byteReady === 1'b1) begin
      if (stallCnt >= curStall && dataQ.size() != 0) begin
        byteValid = 1'b1;
        byteData  = dataQ[0];
      end
      stallCnt++;
    end else begin
      if (byteValid && dataQ.size() != 0) void'(dataQ.pop_front());
      byteValid = 1'b0;
      stallCnt  = 0;
    end
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      report();
      $finish;
    end
  end

  task automatic startXfer(input logic [7:0] a, input logic [7:0] bytes[$], input int stall, input bit modelIt);
    @(negedge clk); #1;
    startReq = 1'b1;
    addrByte = a;
    dataLen  = LEN_W'(bytes.size());
    if (modelIt) begin
      curStall = stall;
      foreach (bytes[i]) dataQ.push_back(bytes[i]);
      modelTransfer(a, bytes, stall);
    end
    @(negedge clk); #1;
    startReq = 1'b0;
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic setTiming(input int h, input int s, input int hi, input int mh, input int mp, input int ms);
    tHold = CNT_W'(h); tSetup = CNT_W'(s); tHigh = CNT_W'(hi);
    tModeHold = CNT_W'(mh); tModePulse = CNT_W'(mp); tModeSetup = CNT_W'(ms);
  endtask

  initial begin
    logic [7:0] q[$];
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #2;
    checks++;  // R1 reset state
    if ({busClk, busData, busMode, busy, done, byteReady} !== 6'b110000)
      fail(1, "reset state", int'({busClk, busData, busMode, busy, done, byteReady}), 6'b110000);
    running = 1'b1;

    // all counts zero: one-cycle minimum everywhere, single byte (R2, R3, R4, R7, R9)
    setTiming(0, 0, 0, 0, 0, 0);
    q = '{8'hA5};
    startXfer(8'h14, q, 0, 1'b1);
    waitDrain();

    // mixed timing, three bytes, inter-byte gaps (R5, R8, R6)
    setTiming(2, 3, 1, 4, 2, 3);
    q = '{8'h3C, 8'h81, 8'hFF};
    startXfer(8'h16, q, 0, 1'b1);
    waitDrain();

    // maximum length with stalled handshake; start while busy ignored (R10)
    setTiming(1, 2, 5, 1, 3, 2);
    q = '{8'h01, 8'h80, 8'h5A, 8'h00};
    startXfer(8'hC3, q, 2, 1'b1);
    repeat (30) @(negedge clk);
    q = '{8'h77, 8'h66};
    startXfer(8'h99, q, 0, 1'b0);   // R10: not modelled, must not disturb
    idleTag = 10;
    waitDrain();
    repeat (10) @(negedge clk);

    // illegal lengths ignored (R11)
    idleTag = 11;
    @(negedge clk); #1;
    startReq = 1'b1; dataLen = '0; addrByte = 8'h55;
    @(negedge clk); #1;
    dataLen = LEN_W'(MAX_LEN + 1);
    @(negedge clk); #1;
    startReq = 1'b0;
    repeat (12) @(negedge clk);
    idleTag = 1;

    // back-to-back short transfer after idle (R1, R2)
    setTiming(3, 1, 2, 2, 1, 1);
    q = '{8'hE7, 8'h18};
    startXfer(8'h2B, q, 1, 1'b1);
    waitDrain();

    running = 1'b0;
    report();
    $finish;
  end

endmodule